// File: doc/BRIEF.md
# Bit Clock Phase Alignment Controller

This controller moves a forwarded bit clock through a 32-step programmable input delay until the internally buffered copy of that clock lines up with one edge of the clock as it arrives at the pins. The clock is also fed into a deserializer as if it were data, clocked by its own delayed copy. That deserializer returns an 8-bit word to the controller. When every bit of the word is equal, the sampling point lies on a flat part of the clock. A mixed word means the sampling point lies in the jitter zone around an edge. The controller runs on the divided clock. It commands the delay one tap at a time with an enable pulse and a direction bit, and it keeps its own copy of the current tap.

An alignment run first probes a few taps below the preset start tap. It then either locks at once, or sweeps upward (wrapping past the last tap) to find the edge. When the run ends, the controller reports four results. It gives the tap it settled on and which kind of external edge it locked to. The edge flag drives the bit-swap selector in the data path. It also reports which of four situations it met and, when no edge exists in the delay span, the clock level it saw. After every tap move the controller waits a programmable settling time. It then judges the level from several consecutive words, not from a single one.

Top module: `bclk_align_ctrl`

## Requirements
- R1: After reset, `tap_o` is 16, `done` is 0, `case_o` is 0 and no delay pulse is issued. Alignment starts only once both `clk_ok` and `cal_ok` are 1. One of them alone starts nothing.
- R2: Every tap move is a single-cycle `dly_ce` pulse. `dly_inc`=1 means one tap up and 0 means one tap down. `tap_o` follows each pulse by exactly one tap and wraps between 31 and 0 in both directions.
- R3: Between two pulses there are always more than `SETTLE` cycles. A tap is classed "ones" only if all `NSMP` consecutive words are 8'hFF. It is classed "zeros" only if all of them are 8'h00. Anything else, including a mix of all-ones and all-zeros words, is "unstable".
- R4: Every run first measures tap 16. It then steps down to taps 15, 14 and 13, measuring at each, and then steps back up to 16. That is six pulses when the run locks there.
- R5: If tap 16 is unstable, the lock is at tap 16 with `case_o`=0. `fall_o`=1 (falling edge) if tap 13 is ones. Otherwise `fall_o`=0 (rising edge).
- R6: If tap 16 is stable and any of taps 15..13 differs from it, the lock is at tap 16 with `case_o`=0. A ones start gives `fall_o`=0. A zeros start gives `fall_o`=1.
- R7: If tap 16 is stable and taps 15..13 match it, taps 17, 18, … are measured in turn until a tap shows the opposite level. Zeros to ones gives `fall_o`=0 and ones to zeros gives `fall_o`=1. The final tap is the floor midpoint of the run of unstable taps just before that tap, or the opposite-level tap itself if there is no such run. A return to the start level clears the run. The move to the final tap uses down pulses. If the edge is reached without wrapping, `case_o`=1.
- R8: The sweep wraps from 31 to 0. An edge found at taps 0..15 gives `case_o`=2. The midpoint is taken around the ring, so a run 30,31,0,1 gives tap 31.
- R9: If 32 sweep steps find no opposite level, the controller moves to tap 0 with up pulses. It sets `case_o`=3, `fall_o`=0, and `lvl_o` to 1 for a ones level or 0 for a zeros level. `lvl_o` is 0 in every other case.
- R10: Once `done` is 1 it stays 1 until reset. No further pulses are issued, and `tap_o`, `fall_o`, `case_o` and `lvl_o` hold whatever the sample words do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ok | input | 1 | Clock manager locked |
| cal_ok | input | 1 | Delay calibration ready |
| smp_word | input | 8 | Parallel word of the bit clock sampled by its delayed copy |
| dly_ce | output | 1 | One-cycle tap move pulse |
| dly_inc | output | 1 | Move direction, 1 = up |
| tap_o | output | 5 | Shadow tap value |
| done | output | 1 | Alignment finished and held |
| fall_o | output | 1 | 1 = locked to falling external edge |
| case_o | output | 2 | 0 crossover at start, 1 forward edge, 2 edge after wrap, 3 no edge |
| lvl_o | output | 1 | Clock level recorded when no edge exists |

## Verification
A wrong internal state shows up at the ports in two ways. It can show as a pulse train that differs from the walk laid out in the requirements: too many or too few pulses, the wrong direction, or pulses spaced too closely. It can also show as a final tap or edge flag that differs from what the sampled profile implies. A lost shadow count appears as a mismatch between `tap_o` and the delay model within one cycle of a pulse. A misjudged level or a bad midpoint appears only when `done` rises, a few hundred cycles into the run. That is why every profile is chosen so that each branch leads to a distinct tap, edge flag and case code. A `done` that is not sticky, or a locked state that is not quiet, appears in the cycles after the lock.

// File: rtl/bca_pkg.sv
package bca_pkg;

  typedef enum logic [1:0] {
    CL_ZERO = 2'd0,
    CL_ONE  = 2'd1,
    CL_UNST = 2'd2
  } lvl_cls_e;

  typedef enum logic [1:0] {
    AC_CROSS = 2'd0,
    AC_FWD   = 2'd1,
    AC_WRAP  = 2'd2,
    AC_NONE  = 2'd3
  } align_case_e;

  // Level class from the accumulated "all ones" / "all zeros" flags.
  function automatic lvl_cls_e word_class(input logic all_ones, input logic all_zeros);
    if (all_ones)  return CL_ONE;
    if (all_zeros) return CL_ZERO;
    return CL_UNST;
  endfunction

  // Floor midpoint of the ring segment running upward from lo to hi.
  function automatic int unsigned ring_mid(input int unsigned lo, input int unsigned hi,
                                           input int unsigned n);
    return (lo + ((hi + n - lo) % n) / 2) % n;
  endfunction

  // Number of downward steps from a to b on a ring of n taps.
  function automatic int unsigned ring_dist(input int unsigned a, input int unsigned b,
                                            input int unsigned n);
    return (a + n - b) % n;
  endfunction

endpackage

// File: rtl/bca_tapreg.sv
module bca_tapreg #(
  parameter int TAPS      = 32,
  parameter int START_TAP = 16,
  localparam int TAP_W    = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_req,
  input  logic             step_up,
  output logic             dly_ce,
  output logic             dly_inc,
  output logic [TAP_W-1:0] tap
);

  localparam logic [TAP_W-1:0] TAP0 = TAP_W'(START_TAP);
  localparam logic [TAP_W-1:0] UNIT = TAP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_ce  <= 1'b0;
      dly_inc <= 1'b0;
      tap     <= TAP0;
    end else begin
      dly_ce <= step_req;
      if (step_req) begin
        dly_inc <= step_up;
        tap     <= step_up ? tap + UNIT : tap - UNIT;
      end
    end
  end

endmodule

// File: rtl/bca_sampler.sv
module bca_sampler import bca_pkg::*; #(
  parameter int W      = 8,
  parameter int SETTLE = 6,
  parameter int NSMP   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] word,
  output logic         vld,
  output lvl_cls_e     cls
);

  localparam int CMAX = (SETTLE > NSMP) ? SETTLE : NSMP;
  localparam int CW   = $clog2(CMAX + 1);

  logic          busy, sampling, acc1, acc0;
  logic [CW-1:0] cnt;
  logic          w_ones, w_zeros;

  assign w_ones  = &word;
  assign w_zeros = ~|word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sampling <= 1'b0;
      cnt      <= '0;
      acc1     <= 1'b1;
      acc0     <= 1'b1;
      vld      <= 1'b0;
      cls      <= CL_UNST;
    end else begin
      vld <= 1'b0;
      if (go) begin
        busy     <= 1'b1;
        sampling <= 1'b0;
        cnt      <= CW'(SETTLE);
        acc1     <= 1'b1;
        acc0     <= 1'b1;
      end else if (busy) begin
        if (!sampling) begin
          if (cnt == '0) begin
            sampling <= 1'b1;
            cnt      <= CW'(NSMP - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end else begin
          acc1 <= acc1 & w_ones;
          acc0 <= acc0 & w_zeros;
          if (cnt == '0) begin
            busy <= 1'b0;
            vld  <= 1'b1;
            cls  <= word_class(acc1 & w_ones, acc0 & w_zeros);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/bca_seq.sv
module bca_seq import bca_pkg::*; #(
  parameter int TAPS      = 32,
  parameter int START_TAP = 16,
  parameter int BACK      = 3,
  localparam int TAP_W    = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_ok,
  input  logic             meas_vld,
  input  lvl_cls_e         meas_cls,
  input  logic [TAP_W-1:0] tap,
  output logic             step_req,
  output logic             step_up,
  output logic             meas_go,
  output logic             done,
  output logic             fall,
  output align_case_e      acase,
  output logic             lvl
);

  localparam int CNT_W = TAP_W + 1;
  localparam logic [CNT_W-1:0] BACK_C = CNT_W'(BACK);
  localparam logic [CNT_W-1:0] TAPS_C = CNT_W'(TAPS);
  localparam logic [CNT_W-1:0] SPAN_C = CNT_W'(TAPS - START_TAP);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_LOCK} st_e;
  typedef enum logic [2:0] {PH_START, PH_BACK, PH_RET, PH_SWEEP, PH_GO} ph_e;

  st_e              st;
  ph_e              ph;
  logic             mv_en, up, chg, uvalid;
  logic [CNT_W-1:0] cnt, mv;
  lvl_cls_e         c0, cb;
  logic [TAP_W-1:0] first_u, last_u;

  // Named intermediate results.
  logic [CNT_W-1:0] k_c, back_dist_c, zero_dist_c;
  logic [TAP_W-1:0] mid_c, tgt_c;
  lvl_cls_e         opp_c;
  logic             hit_c, wrapped_c;

  assign k_c         = cnt + ONE_C;
  assign opp_c       = (c0 == CL_ONE) ? CL_ZERO : CL_ONE;
  assign hit_c       = (meas_cls == opp_c);
  assign mid_c       = TAP_W'(ring_mid(32'(first_u), 32'(last_u), TAPS));
  assign tgt_c       = uvalid ? mid_c : tap;
  assign back_dist_c = CNT_W'(ring_dist(32'(tap), 32'(tgt_c), TAPS));
  assign zero_dist_c = CNT_W'(ring_dist(32'd0, 32'(tap), TAPS));
  assign wrapped_c   = (k_c >= SPAN_C);

  assign step_req = (st == ST_ISSUE) && mv_en;
  assign meas_go  = (st == ST_ISSUE);
  assign step_up  = up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_START;
      mv_en   <= 1'b0;
      up      <= 1'b0;
      chg     <= 1'b0;
      uvalid  <= 1'b0;
      cnt     <= '0;
      mv      <= '0;
      c0      <= CL_UNST;
      cb      <= CL_UNST;
      first_u <= '0;
      last_u  <= '0;
      done    <= 1'b0;
      fall    <= 1'b0;
      acase   <= AC_CROSS;
      lvl     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (run_ok) begin
            st    <= ST_ISSUE;
            mv_en <= 1'b0;
            ph    <= PH_START;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (meas_vld) begin
            st    <= ST_ISSUE;
            mv_en <= 1'b1;
            case (ph)
              PH_START: begin
                c0  <= meas_cls;
                ph  <= PH_BACK;
                cnt <= '0;
                up  <= 1'b0;
              end
              PH_BACK: begin
                if (meas_cls != c0) chg <= 1'b1;
                cb  <= meas_cls;
                cnt <= k_c;
                if (k_c >= BACK_C) begin
                  ph <= PH_RET;
                  mv <= BACK_C;
                  up <= 1'b1;
                end else begin
                  up <= 1'b0;
                end
              end
              PH_RET: begin
                up <= 1'b1;
                if (mv == ONE_C) begin
                  if (c0 == CL_UNST) begin
                    fall  <= (cb == CL_ONE);
                    acase <= AC_CROSS;
                    st    <= ST_LOCK;
                    done  <= 1'b1;
                    mv_en <= 1'b0;
                  end else if (chg) begin
                    fall  <= (c0 == CL_ZERO);
                    acase <= AC_CROSS;
                    st    <= ST_LOCK;
                    done  <= 1'b1;
                    mv_en <= 1'b0;
                  end else begin
                    ph     <= PH_SWEEP;
                    cnt    <= '0;
                    uvalid <= 1'b0;
                  end
                end else begin
                  mv <= mv - ONE_C;
                end
              end
              PH_SWEEP: begin
                cnt <= k_c;
                if (hit_c) begin
                  fall  <= (c0 == CL_ONE);
                  acase <= wrapped_c ? AC_WRAP : AC_FWD;
                  up    <= 1'b0;
                  if (back_dist_c == '0) begin
                    st    <= ST_LOCK;
                    done  <= 1'b1;
                    mv_en <= 1'b0;
                  end else begin
                    ph <= PH_GO;
                    mv <= back_dist_c;
                  end
                end else begin
                  if (meas_cls == CL_UNST) begin
                    if (!uvalid) first_u <= tap;
                    last_u <= tap;
                    uvalid <= 1'b1;
                  end else begin
                    uvalid <= 1'b0;
                  end
                  up <= 1'b1;
                  if (k_c == TAPS_C) begin
                    acase <= AC_NONE;
                    lvl   <= (c0 == CL_ONE);
                    fall  <= 1'b0;
                    if (zero_dist_c == '0) begin
                      st    <= ST_LOCK;
                      done  <= 1'b1;
                      mv_en <= 1'b0;
                    end else begin
                      ph <= PH_GO;
                      mv <= zero_dist_c;
                    end
                  end
                end
              end
              PH_GO: begin
                if (mv == ONE_C) begin
                  st    <= ST_LOCK;
                  done  <= 1'b1;
                  mv_en <= 1'b0;
                end else begin
                  mv <= mv - ONE_C;
                end
              end
              default: st <= ST_LOCK;
            endcase
          end
        end
        ST_LOCK: st <= ST_LOCK;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bclk_align_ctrl.sv
module bclk_align_ctrl import bca_pkg::*; #(
  parameter int W         = 8,
  parameter int TAPS      = 32,
  parameter int START_TAP = 16,
  parameter int BACK      = 3,
  parameter int SETTLE    = 6,
  parameter int NSMP      = 4,
  localparam int TAP_W    = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_ok,
  input  logic             cal_ok,
  input  logic [W-1:0]     smp_word,
  output logic             dly_ce,
  output logic             dly_inc,
  output logic [TAP_W-1:0] tap_o,
  output logic             done,
  output logic             fall_o,
  output logic [1:0]       case_o,
  output logic             lvl_o
);

  logic        step_fire, step_up, meas_go, meas_vld;
  lvl_cls_e    meas_cls;
  align_case_e acase;

  bca_tapreg #(.TAPS(TAPS), .START_TAP(START_TAP)) u_tap (
    .clk(clk), .rst_n(rst_n), .step_req(step_fire), .step_up(step_up),
    .dly_ce(dly_ce), .dly_inc(dly_inc), .tap(tap_o)
  );

  bca_sampler #(.W(W), .SETTLE(SETTLE), .NSMP(NSMP)) u_smp (
    .clk(clk), .rst_n(rst_n), .go(meas_go), .word(smp_word),
    .vld(meas_vld), .cls(meas_cls)
  );

  bca_seq #(.TAPS(TAPS), .START_TAP(START_TAP), .BACK(BACK)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_ok(clk_ok & cal_ok),
    .meas_vld(meas_vld), .meas_cls(meas_cls), .tap(tap_o),
    .step_req(step_fire), .step_up(step_up), .meas_go(meas_go),
    .done(done), .fall(fall_o), .acase(acase), .lvl(lvl_o)
  );

  assign case_o = acase;

endmodule

// File: rtl/bca_chk.sv
module bca_chk #(
  parameter int TAPS      = 32,
  parameter int START_TAP = 16,
  parameter int SETTLE    = 6,
  localparam int TAP_W    = $clog2(TAPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_ok,
  input logic             cal_ok,
  input logic             dly_ce,
  input logic             dly_inc,
  input logic [TAP_W-1:0] tap_o,
  input logic             done,
  input logic             fall_o,
  input logic [1:0]       case_o,
  input logic             lvl_o,
  input logic             meas_vld
);

  logic             started, seen;
  logic [TAP_W-1:0] prev_tap;
  logic [15:0]      gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      seen     <= 1'b0;
      prev_tap <= TAP_W'(START_TAP);
      gap      <= '0;
    end else begin
      started  <= started | (clk_ok & cal_ok);
      prev_tap <= tap_o;
      if (dly_ce) begin
        seen <= 1'b1;
        gap  <= '0;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 16'd1;
      end
    end
  end

  p_quiet_before_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !dly_ce);

  p_tap_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_ce && dly_inc) |-> (tap_o == TAP_W'(prev_tap + TAP_W'(1))));

  p_tap_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_ce && !dly_inc) |-> (tap_o == TAP_W'(prev_tap - TAP_W'(1))));

  p_tap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_ce |-> (tap_o == prev_tap));

  p_settle_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_ce && seen) |-> (gap >= 16'(SETTLE)));

  p_judge_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |-> !dly_ce);

  p_cross_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && case_o == 2'd0) |-> (tap_o == TAP_W'(START_TAP)));

  p_none_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && case_o == 2'd3) |-> (tap_o == '0));

  p_lvl_only_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && case_o != 2'd3) |-> !lvl_o);

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_locked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dly_ce);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(tap_o) && $stable(fall_o) && $stable(case_o)));

endmodule

bind bclk_align_ctrl bca_chk #(.TAPS(TAPS), .START_TAP(START_TAP), .SETTLE(SETTLE)) u_bca_chk (
  .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .cal_ok(cal_ok),
  .dly_ce(dly_ce), .dly_inc(dly_inc), .tap_o(tap_o), .done(done),
  .fall_o(fall_o), .case_o(case_o), .lvl_o(lvl_o), .meas_vld(meas_vld)
);

// File: tb/tb_bclk_align_ctrl.sv
`timescale 1ns/1ps
module tb_bclk_align_ctrl;

  localparam int SETTLE = 6;
  localparam int NSMP   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_ok = 1'b0;
  logic       cal_ok = 1'b0;
  logic [7:0] smp_word = 8'h00;
  logic       dly_ce, dly_inc, done, fall_o, lvl_o;
  logic [4:0] tap_o;
  logic [1:0] case_o;

  always #10 clk = ~clk;

  bclk_align_ctrl #(.SETTLE(SETTLE), .NSMP(NSMP)) dut (
    .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .cal_ok(cal_ok),
    .smp_word(smp_word), .dly_ce(dly_ce), .dly_inc(dly_inc), .tap_o(tap_o),
    .done(done), .fall_o(fall_o), .case_o(case_o), .lvl_o(lvl_o)
  );

  // Tap profile: 0 = low, 1 = high, 2 = jittery mixed words, 3 = alternating FF/00.
  int prof [32];
  int m_tap, pulses, gap, min_gap, min_tap, ph_ctr;
  int n_checks = 0, n_fails = 0, cycles = 0;

  function automatic logic [7:0] word_for(int p, int ph);
    logic [7:0] mixed [4] = '{8'h3C, 8'h5A, 8'h0F, 8'hE1};
    case (p)
      0: return 8'h00;
      1: return 8'hFF;
      2: return mixed[ph % 4];
      default: return (ph % 2 == 1) ? 8'hFF : 8'h00;
    endcase
  endfunction

  // Delay line and deserializer model, updated away from the active edge.
  always @(negedge clk) begin
    ph_ctr = ph_ctr + 1;
    if (!rst_n) begin
      m_tap = 16; pulses = 0; gap = 0; min_gap = 1000000; min_tap = 16;
    end else if (dly_ce) begin
      if (pulses > 0 && gap < min_gap) min_gap = gap;
      gap = 0;
      pulses = pulses + 1;
      m_tap = dly_inc ? (m_tap + 1) % 32 : (m_tap + 31) % 32;
      if (m_tap < min_tap) min_tap = m_tap;
    end else begin
      gap = gap + 1;
    end
    smp_word = word_for(prof[m_tap], ph_ctr);
  end

  function automatic int cls_of(int p);
    return (p >= 2) ? 2 : p;
  endfunction

  // Expected outcome, worked out from the requirements.
  task automatic ref_align(output int e_tap, output int e_fall, output int e_case,
                           output int e_lvl);
    int c0, cb, t, fu, lu, c;
    bit chg, uv;
    c0 = cls_of(prof[16]);
    cb = cls_of(prof[13]);
    chg = 0;
    for (int s = 1; s <= 3; s++) if (cls_of(prof[16 - s]) != c0) chg = 1;
    e_lvl = 0;
    if (c0 == 2) begin e_tap = 16; e_case = 0; e_fall = (cb == 1) ? 1 : 0; return; end
    if (chg) begin e_tap = 16; e_case = 0; e_fall = (c0 == 0) ? 1 : 0; return; end
    uv = 0; fu = 0; lu = 0;
    for (int k = 1; k <= 32; k++) begin
      t = (16 + k) % 32;
      c = cls_of(prof[t]);
      if (c == 1 - c0) begin
        e_fall = (c0 == 1) ? 1 : 0;
        e_case = (t < 16) ? 2 : 1;
        e_tap  = uv ? (fu + ((lu - fu + 32) % 32) / 2) % 32 : t;
        return;
      end
      if (c == 2) begin if (!uv) fu = t; lu = t; uv = 1; end
      else uv = 0;
    end
    e_tap = 0; e_case = 3; e_fall = 0; e_lvl = (c0 == 1) ? 1 : 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill(input int lo, input int hi, input int v);
    for (int i = lo; i <= hi; i++) prof[i] = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; clk_ok = 1'b0; cal_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_align(input string req);
    int e_tap, e_fall, e_case, e_lvl, wd;
    do_reset();
    clk_ok = 1'b1; cal_ok = 1'b1;
    wd = 0;
    while (!done && wd < 4000) begin @(negedge clk); wd++; end
    ref_align(e_tap, e_fall, e_case, e_lvl);
    check(done === 1'b1, req, "done", int'(done), 1);
    check(int'(tap_o) == e_tap, req, "tap", int'(tap_o), e_tap);
    check(int'(fall_o) == e_fall, req, "fall", int'(fall_o), e_fall);
    check(int'(case_o) == e_case, req, "case", int'(case_o), e_case);
    check(int'(lvl_o) == e_lvl, req, "level", int'(lvl_o), e_lvl);
    check(m_tap == int'(tap_o), "R2", "shadow vs delay", int'(tap_o), m_tap);
    check(min_gap > SETTLE, "R3", "pulse spacing", min_gap, SETTLE + 1);
  endtask

  task automatic test_reset();  // R1
    do_reset();
    repeat (100) @(negedge clk);
    check(done == 1'b0, "R1", "done idle", int'(done), 0);
    check(tap_o == 5'd16, "R1", "start tap", int'(tap_o), 16);
    check(case_o == 2'd0, "R1", "case idle", int'(case_o), 0);
    check(pulses == 0, "R1", "pulses without ready", pulses, 0);
    clk_ok = 1'b1;
    repeat (50) @(negedge clk);
    check(pulses == 0, "R1", "pulses with one ready", pulses, 0);
    cal_ok = 1'b1;
    repeat (60) @(negedge clk);
    check(pulses > 0, "R1", "starts when both ready", pulses, 1);
  endtask

  task automatic test_cross_fall();  // R5, R4
    fill(0, 31, 1); prof[16] = 2;
    run_align("R5");
    check(min_tap == 13, "R4", "lowest probe tap", min_tap, 13);
    check(pulses == 6, "R4", "probe pulse count", pulses, 6);
  endtask

  task automatic test_cross_rise();  // R5
    fill(0, 31, 0); prof[16] = 2;
    run_align("R5");
  endtask

  task automatic test_alt_judge();  // R3
    fill(0, 31, 0); prof[15] = 3;
    run_align("R3");
  endtask

  task automatic test_back_rise();  // R6
    fill(0, 31, 1); prof[14] = 2;
    run_align("R6");
  endtask

  task automatic test_back_fall();  // R6
    fill(0, 31, 0); prof[13] = 1;
    run_align("R6");
  endtask

  task automatic test_fwd_span();  // R7
    fill(0, 31, 1); fill(8, 19, 0); fill(20, 22, 2);
    run_align("R7");
  endtask

  task automatic test_fwd_direct();  // R7
    fill(0, 31, 0); fill(10, 19, 1);
    run_align("R7");
  endtask

  task automatic test_fwd_restart();  // R7
    fill(0, 31, 1); fill(5, 19, 0); prof[20] = 2; prof[21] = 0; fill(22, 23, 2);
    run_align("R7");
  endtask

  task automatic test_wrap();  // R8
    fill(0, 31, 0); fill(30, 31, 2); fill(0, 1, 2); fill(2, 3, 1);
    run_align("R8");
  endtask

  task automatic test_none_ones();  // R9
    fill(0, 31, 1);
    run_align("R9");
  endtask

  task automatic test_none_zeros();  // R9
    fill(0, 31, 0);
    run_align("R9");
  endtask

  task automatic test_hold();  // R10
    int t0, f0, c0, p0;
    fill(0, 31, 1); fill(8, 19, 0); fill(20, 22, 2);
    run_align("R10");
    t0 = int'(tap_o); f0 = int'(fall_o); c0 = int'(case_o); p0 = pulses;
    fill(0, 31, 2);
    repeat (300) @(negedge clk);
    check(done == 1'b1, "R10", "done held", int'(done), 1);
    check(pulses == p0, "R10", "no pulses while locked", pulses, p0);
    check(int'(tap_o) == t0, "R10", "tap held", int'(tap_o), t0);
    check(int'(fall_o) == f0, "R10", "fall held", int'(fall_o), f0);
    check(int'(case_o) == c0, "R10", "case held", int'(case_o), c0);
  endtask

  initial begin
    ph_ctr = 0; m_tap = 16; pulses = 0; gap = 0; min_gap = 1000000; min_tap = 16;
    fill(0, 31, 0);
    test_reset();
    test_cross_fall();
    test_cross_rise();
    test_alt_judge();
    test_back_rise();
    test_back_fall();
    test_fwd_span();
    test_fwd_direct();
    test_fwd_restart();
    test_wrap();
    test_none_ones();
    test_none_zeros();
    test_hold();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
      end
    end
  end

endmodule